// File: doc/BRIEF.md
# Clocked Host Port for an External 8K x 8 Asynchronous Static RAM

This block sits between a synchronous host and an external asynchronous static RAM of 8192 bytes. The host offers one transfer at a time on a valid/ready request channel: a write flag, a 13-bit word address and, for writes, a byte of data. The controller turns each transfer into a sequence of memory strobes whose lengths are counted in clock cycles. It reports completion with a single-cycle done pulse. For a read, that pulse carries the captured byte.

The memory is selected only while its active-low select is low and its active-high select is high together. Reads hold the output enable low and the write strobe high for a whole read slot. The byte is sampled once the configured access count has run out. When a further read is accepted in the last cycle of a slot, both selects and the output enable stay on and only the address moves. A read slot always lasts at least the minimum read cycle count. Writes run through three phases: one clock of setup, a write-strobe pulse of programmable width, and one clock of hold. The data drivers are enabled only for those phases, and only while the output enable is high. When no transfer is pending, both selects drop and the memory goes to standby.

Request back-pressure: the host keeps `req_valid` and the request fields stable until it sees `req_ready` high at a rising edge. The response channel has no ready: `rsp_valid` is high for exactly one cycle, and `rsp_rdata` holds its value until the next read completes.

Top module: `sram_ctl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, the memory pins are idle: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0. `req_ready` is 1 and `rsp_valid` is 0. A reset that arrives in the middle of a write returns the pins to this state at the next edge.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only when the controller is idle or in the last cycle of a read slot. In the cycle after the request is taken, the memory is selected (`mem_ce1_n`=0, `mem_ce2`=1).
- R3: Throughout a read, the memory is selected, `mem_we_n`=1 and `mem_oe_n`=0. The requested address is on `mem_addr`.
- R4: A read raises `rsp_valid` ACCESS_CYC+1 cycles after the request is taken. `rsp_rdata` then holds the value that was on `mem_dq_in` after ACCESS_CYC full cycles of stable address, select and output enable.
- R5: A read taken in the last cycle of a read slot keeps both selects and `mem_oe_n` asserted and changes only `mem_addr`. Successive address changes are at least RD_LEN = max(ACCESS_CYC, CYCLE_CYC) cycles apart.
- R6: A write runs as follows: one setup cycle with the memory selected, `mem_we_n`=1 and data driven; WPULSE_CYC cycles with `mem_we_n`=0; one hold cycle with `mem_we_n`=1. `rsp_valid` is then high WPULSE_CYC+3 cycles after the request was taken.
- R7: `mem_dq_oe` is 1 only during the three write phases, and never while `mem_oe_n` is 0.
- R8: With no request pending, both selects are deasserted once the current transfer ends.
- R9: `rsp_valid` is never high in two consecutive cycles.
- R10: `mem_addr` and `mem_dq_out` hold the same value from the setup cycle through the hold cycle. This covers the cycle after `mem_we_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Byte captured by the last read |
| mem_ce1_n | output | 1 | Memory select, active low |
| mem_ce2 | output | 1 | Memory select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_in | input | DATA_W | Data from the memory pads |

## Verification
The properties assume that the host follows the request rule: once `req_valid` is high, the request fields do not change until the request is taken. They also assume that the write flag of an offered request is fixed. The bench drives requests at falling edges, holds them until an edge finds `req_ready` high, and withdraws them just after that edge. The bench memory model returns a filler byte until ACCESS_CYC falling-edge samples in a row have seen the same address with the read strobes set. A capture made even one cycle early therefore shows up as a wrong byte.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSU  = 3'd2,
    ST_WPL  = 3'd3,
    ST_WHD  = 3'd4
  } sram_st_e;
endpackage

// File: rtl/sram_ctl_cnt.sv
`timescale 1ns/1ps
// Up counter for phase lengths; cleared whenever the phase changes.
module sram_ctl_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) val <= '0;
    else               val <= val + 1'b1;
  end
endmodule

// File: rtl/sram_ctl_resp.sv
`timescale 1ns/1ps
// Response register: latches read data and forms the one-cycle done pulse.
module sram_ctl_resp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              wr_done,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en | wr_done;
      if (cap_en) rsp_rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int ACCESS_CYC = 3,
  parameter int CYCLE_CYC  = 5,
  parameter int WPULSE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RD_LEN = (CYCLE_CYC > ACCESS_CYC) ? CYCLE_CYC : ACCESS_CYC;
  localparam int MAXC   = (RD_LEN > WPULSE_CYC) ? RD_LEN : WPULSE_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] CAP_AT   = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] WPL_LAST = CNT_W'(WPULSE_CYC - 1);

  sram_st_e         state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             rd_last;
  logic             accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign rd_last   = (state == ST_RD) && (cnt == RD_LAST);
  assign req_ready = (state == ST_IDLE) || rd_last;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (accept) nxt = req_write ? ST_WSU : ST_RD;
      ST_RD:   if (rd_last) nxt = accept ? (req_write ? ST_WSU : ST_RD) : ST_IDLE;
      ST_WSU:  nxt = ST_WPL;
      ST_WPL:  if (cnt == WPL_LAST) nxt = ST_WHD;
      ST_WHD:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  // a new read slot restarts the count even though the state stays put
  assign cnt_clr = (nxt != state) || rd_last;

  sram_ctl_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .val   (cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  // pin decode straight from the state register
  assign mem_ce1_n  = (state == ST_IDLE);
  assign mem_ce2    = (state != ST_IDLE);
  assign mem_oe_n   = (state != ST_RD);
  assign mem_we_n   = (state != ST_WPL);
  assign mem_dq_oe  = (state == ST_WSU) || (state == ST_WPL) || (state == ST_WHD);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  sram_ctl_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    ((state == ST_RD) && (cnt == CAP_AT)),
    .wr_done   (state == ST_WHD),
    .dq_in     (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int RD_LEN = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  logic [7:0]        gap;
  logic [ADDR_W-1:0] addr_prev;
  logic              oe_prev_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap         <= '0;
      addr_prev   <= '0;
      oe_prev_low <= 1'b0;
    end else begin
      addr_prev   <= mem_addr;
      oe_prev_low <= !mem_oe_n;
      if (mem_addr != addr_prev) gap <= 8'd1;
      else if (gap != 8'hFF)     gap <= gap + 8'd1;
    end
  end

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  // R6
  we_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe));
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));
  // R10
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
  // R3
  rd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce1_n && mem_ce2 && mem_we_n));
  // R2
  accept_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!mem_ce1_n && mem_ce2));
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R5
  rd_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && oe_prev_low && (mem_addr != addr_prev)) |-> (gap >= 8'(RD_LEN)));
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LEN(RD_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_ce1_n  (mem_ce1_n),
  .mem_ce2    (mem_ce2),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;
  localparam int AW = 13, DW = 8, ACC = 3, CYC = 5, WPL = 2;
  localparam int RDL = (CYC > ACC) ? CYC : ACC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = 8'hEE;

  always #2.5 clk = ~clk;

  sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC), .CYCLE_CYC(CYC), .WPULSE_CYC(WPL)) i_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model, bench-side expected contents
  logic [DW-1:0] mdl_mem [int];
  logic [DW-1:0] exp_mem [int];
  int age = 0, cyc = 0, we_low = 0, rsp_cnt = 0, last_rsp = 0, prev_rsp = 0, sel_drop = 0;
  logic [AW-1:0] last_a = '0;
  bit last_rd = 0, prev_v = 0;

  always @(negedge clk) begin
    bit sel, rd_en;
    cyc++;
    sel = !mem_ce1_n && mem_ce2;
    if (sel && !mem_we_n) begin
      mdl_mem[int'(mem_addr)] = mem_dq_out;
      we_low++;
    end
    rd_en = sel && mem_we_n && !mem_oe_n;
    if (!rd_en) age = 0;
    else if (mem_addr != last_a || !last_rd) age = 1;
    else age++;
    last_a = mem_addr;
    last_rd = rd_en;
    if (rd_en && age >= ACC)
      mem_dq_in = mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'hEE;
    if (!sel) sel_drop++;
    if (rsp_valid) begin
      if (prev_v) chk(0, "R9 done pulse two cycles", 1, 0);
      rsp_cnt++;
      prev_rsp = last_rsp;
      last_rsp = cyc;
    end
    prev_v = rsp_valid;
  end

  // {write, addr, data}
  localparam logic [21:0] VEC [9] = '{
    {1'b1, 13'h0000, 8'hA5}, {1'b1, 13'h1FFF, 8'h3C}, {1'b1, 13'h0ABC, 8'h7E},
    {1'b0, 13'h1FFF, 8'h00}, {1'b0, 13'h0000, 8'h00}, {1'b0, 13'h0ABC, 8'h00},
    {1'b1, 13'h0ABC, 8'h81}, {1'b0, 13'h0ABC, 8'h00}, {1'b0, 13'h1234, 8'h00}};

  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    we_low = 0;
    @(posedge clk); #1;
    req_valid = 0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 50);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 pins in reset",
        {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    chk(req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce1_n && !mem_ce2 && req_ready, "R1 idle after reset", {mem_ce1_n, mem_ce2, req_ready}, 3'b101);

    foreach (VEC[i]) begin
      bit w = VEC[i][21];
      logic [AW-1:0] a = VEC[i][20:8];
      logic [DW-1:0] d = VEC[i][7:0];
      xfer(w, a, d, lat);
      if (w) begin
        exp_mem[int'(a)] = d;
        chk(lat == WPL + 3, "R6 write done latency", lat, WPL + 3);
        chk(we_low == WPL, "R6 write strobe width", we_low, WPL);
      end else begin
        logic [DW-1:0] e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
        chk(lat == ACC + 1, "R4 read done latency", lat, ACC + 1);
        chk(rsp_rdata == e, "R4 read data", rsp_rdata, e);
        chk(!mem_oe_n && !mem_ce1_n && mem_ce2 && mem_we_n && mem_addr == a, "R3 read strobes",
            {mem_oe_n, mem_ce1_n, mem_ce2, mem_we_n}, 4'b0011);
      end
      repeat (3) @(negedge clk);
      chk(mem_ce1_n && !mem_ce2 && !mem_dq_oe, "R8 standby after transfer", {mem_ce1_n, mem_ce2}, 2'b10);
    end

    // R5 back-to-back reads: selects stay on, slots RDL apart
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 13'h1FFF;
    @(posedge clk); #1;
    req_addr = 13'h0000;
    sel_drop = 0; rsp_cnt = 0;
    @(negedge clk);
    chk(!req_ready, "R2 ready low inside read slot", req_ready, 0);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    while (rsp_cnt < 2) @(negedge clk);
    chk(sel_drop == 0, "R5 selects held between reads", sel_drop, 0);
    chk(last_rsp - prev_rsp == RDL, "R5 read slot spacing", last_rsp - prev_rsp, RDL);
    chk(rsp_rdata == 8'hA5, "R5 second read data", rsp_rdata, 8'hA5);

    // R1 reset in the middle of a write pulse
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 13'h0055; req_wdata = 8'h11;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk); @(negedge clk);
    chk(!mem_we_n && mem_dq_oe, "R6 pulse phase reached", mem_we_n, 0);
    rst_n = 0;
    @(negedge clk);
    chk(mem_ce1_n && !mem_ce2 && mem_we_n && !mem_dq_oe && mem_oe_n, "R1 reset aborts write",
        {mem_ce1_n, mem_ce2, mem_we_n, mem_dq_oe}, 4'b1010);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 ready after mid-write reset", req_ready, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule